// File: doc/BRIEF.md
# Single-Bit Error Locating Link

This block models a short data link that carries a seven-bit word and can have a single-bit fault injected into it. The data bits are numbered from 1 at the LSB up to 7 at the MSB. A corruption index picks which bit, if any, is inverted on the way from the sending end to the receiving end. The sending end and the receiving end each compute the same group of position-weighted parity checks over the data bits alone. No check bits travel across the link.

Each parity check covers the data bits whose position number has one particular binary digit set. The block compares the sending-end and receiving-end results of each check. Read together, the comparison results form a syndrome whose value is the position of the flipped bit, and zero when the two words agree. The block reports the received word, the syndrome and an error flag. It also reports a repaired word, in which the bit named by the syndrome is inverted back.

The block is purely combinational. The parameter `CHK` sets the number of parity checks. The word width is derived from it as 2^CHK − 1, and the default of 3 gives the seven-bit link.

Top module: `bit_error_link`

## Requirements
- R1: Data bit p (p = 1 to W, with W = 2^CHK − 1) sits at index p of every word port, so bit 1 is the LSB and bit W is the MSB.
- R2: When `flip_idx` is 0, `rx_word` equals `tx_word`.
- R3: When `flip_idx` is i, with i from 1 to W, `rx_word` equals `tx_word` with only bit i inverted, so exactly one bit differs.
- R4: Parity check k (bit k of `syndrome`, k = 0 to CHK−1) is the odd parity of those data bits whose position number has bit k set. It is computed on each side over data bits only.
- R5: Each bit of `syndrome` is the XOR of the sending-side and receiving-side results of its check: 0 on a match, 1 on a mismatch. For any single flip, `syndrome` equals `flip_idx`.
- R6: With no corruption (`flip_idx` = 0), `syndrome` is 0 for every data word.
- R7: `err_flag` is 1 exactly when `syndrome` is nonzero, which is exactly when `rx_word` differs from `tx_word`.
- R8: `fixed_word` is `rx_word` with the bit named by a nonzero syndrome inverted, so it always equals `tx_word`.
- R9: Sending 7'b0000010 with `flip_idx` = 2 gives `rx_word` = 0, `syndrome` = 3'b010 and `err_flag` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tx_word | input | W (7) | Word at the sending end, bits numbered 1..W |
| flip_idx | input | CHK (3) | Position of the bit to invert; 0 injects no fault |
| rx_word | output | W (7) | Word as seen at the receiving end |
| syndrome | output | CHK (3) | Parity mismatch pattern; names the flipped position |
| err_flag | output | 1 | Set when the syndrome is nonzero |
| fixed_word | output | W (7) | Received word with the located bit restored |

## Verification
The bench builds the block with the default `CHK` = 3. That gives a seven-bit word and an eight-value index, so the whole input space of 128 words × 8 indices is within reach. The bench sweeps all of it, and the syndrome, flag and repaired word are checked for every combination, including the all-zero and all-one words and the MSB flip. Smaller directed tasks cover the zero-input state, the worked example, per-check coverage of single positions, and pass-through.

// File: rtl/bit_error_link.sv
module bit_error_link #(
  parameter int CHK = 3,
  localparam int W = (1 << CHK) - 1
) (
  input  logic [W:1]     tx_word,
  input  logic [CHK-1:0] flip_idx,
  output logic [W:1]     rx_word,
  output logic [CHK-1:0] syndrome,
  output logic           err_flag,
  output logic [W:1]     fixed_word
);

  function automatic logic [W:1] cover_mask(input int k);
    logic [W:1] m;
    for (int p = 1; p <= W; p++) m[p] = ((p >> k) & 1) == 1;
    return m;
  endfunction

  logic [CHK-1:0] tx_par, rx_par;

  for (genvar p = 1; p <= W; p++) begin : g_pos
    assign rx_word[p]    = tx_word[p] ^ (flip_idx == CHK'(p));
    assign fixed_word[p] = rx_word[p] ^ (syndrome == CHK'(p));
  end

  for (genvar k = 0; k < CHK; k++) begin : g_chk
    localparam logic [W:1] MASK = cover_mask(k);
    assign tx_par[k]   = ^(tx_word & MASK);
    assign rx_par[k]   = ^(rx_word & MASK);
    assign syndrome[k] = tx_par[k] ^ rx_par[k];
  end

  assign err_flag = |syndrome;

endmodule

// File: rtl/bit_error_link_chk.sv
module bit_error_link_chk #(
  parameter int CHK = 3,
  localparam int W = (1 << CHK) - 1
) (
  input logic [W:1]     tx_word,
  input logic [CHK-1:0] flip_idx,
  input logic [W:1]     rx_word,
  input logic [CHK-1:0] syndrome,
  input logic           err_flag,
  input logic [W:1]     fixed_word
);

  always_comb begin
    if (flip_idx == '0)
      a_r2_pass_through: assert (rx_word == tx_word);
    a_r3_single_flip: assert ($countones(rx_word ^ tx_word) == ((flip_idx != '0) ? 1 : 0));
    a_r5_syndrome_locates: assert (syndrome == flip_idx);
    a_r7_flag_matches_diff: assert (err_flag == (rx_word != tx_word));
    a_r8_repair_restores: assert (fixed_word == tx_word);
  end

endmodule

bind bit_error_link bit_error_link_chk #(.CHK(CHK)) u_chk (
  .tx_word(tx_word), .flip_idx(flip_idx), .rx_word(rx_word),
  .syndrome(syndrome), .err_flag(err_flag), .fixed_word(fixed_word)
);

// File: tb/bit_error_link_tb.sv
module bit_error_link_tb;
  localparam int CHK = 3;
  localparam int W = (1 << CHK) - 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [W:1]     tx_word;
  logic [CHK-1:0] flip_idx;
  logic [W:1]     rx_word, fixed_word;
  logic [CHK-1:0] syndrome;
  logic           err_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit_error_link #(.CHK(CHK)) u_dut (
    .tx_word(tx_word), .flip_idx(flip_idx), .rx_word(rx_word),
    .syndrome(syndrome), .err_flag(err_flag), .fixed_word(fixed_word)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [W:1] w, input logic [CHK-1:0] i);
    @(negedge clk);
    tx_word  = w;
    flip_idx = i;
    #1;
  endtask

  function automatic logic [W:1] flip_exp(input logic [W:1] w, input int i);
    logic [W:1] r = w;
    if (i != 0) r[i] = ~r[i];
    return r;
  endfunction

  task automatic t_zero_state;
    apply('0, '0);
    check("R6 zero syndrome", int'(syndrome), 0);
    check("R7 zero flag", int'(err_flag), 0);
    check("R2 zero rx", int'(rx_word), 0);
    check("R8 zero fixed", int'(fixed_word), 0);
  endtask

  task automatic t_worked_example;
    apply(7'b0000010, 3'd2);
    check("R9 rx", int'(rx_word), 0);
    check("R9 syndrome", int'(syndrome), 2);
    check("R9 flag", int'(err_flag), 1);
    check("R9 fixed", int'(fixed_word), 2);
  endtask

  task automatic t_bit_order;
    for (int p = 1; p <= W; p++) begin
      apply('0, CHK'(p));
      check("R1 position weight", int'(rx_word), 1 << (p - 1));
    end
  endtask

  task automatic t_check_cover;
    for (int p = 1; p <= W; p++) begin
      apply({W{1'b1}}, CHK'(p));
      for (int k = 0; k < CHK; k++)
        check("R4 check covers position", int'(syndrome[k]), (p >> k) & 1);
    end
  endtask

  task automatic t_pass_through;
    for (int w = 0; w < (1 << W); w++) begin
      apply(W'(w), '0);
      check("R2 unchanged", int'(rx_word), w);
      check("R6 no mismatch", int'(syndrome), 0);
    end
  endtask

  task automatic t_full_sweep;
    for (int w = 0; w < (1 << W); w++)
      for (int i = 0; i <= W; i++) begin
        apply(W'(w), CHK'(i));
        check("R3 rx word", int'(rx_word), int'(flip_exp(W'(w), i)));
        check("R5 syndrome", int'(syndrome), i);
        check("R7 flag", int'(err_flag), (i != 0) ? 1 : 0);
        check("R8 repaired", int'(fixed_word), w);
      end
  endtask

  initial begin
    tx_word = '0;
    flip_idx = '0;
    t_zero_state();
    t_worked_example();
    t_bit_order();
    t_check_cover();
    t_pass_through();
    t_full_sweep();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule